// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 256K bytes. The host issues one read or write request at a time through a request/ready handshake. The controller turns each request into strobe phases whose lengths are whole clock cycles. It registers the address and write data for the whole access, drives the two chip enables, the write strobe and the output strobe, and returns captured read data together with a one-cycle completion pulse.

Every phase length is derived at elaboration time from the clock period and a speed grade parameter (grade 0 is the 55 ns part, grade 1 the 70 ns part). Each nanosecond minimum is divided by the clock period, rounded up, and raised to at least one cycle. The controller drives the data bus only while the write strobe is low. After every read it waits out the memory's bus-release time before the bus can be driven again. Between accesses it deselects the RAM so the device stays in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and in every cycle in which `ready` is high, the RAM is deselected: `sram_ce_n`=1, `sram_ce`=0, `sram_we_n`=1, `sram_oe_n`=1 and `sram_dq_oe`=0.
- R2: `sram_we_n` and `sram_oe_n` are never low in the same cycle, and `sram_dq_oe` is never high while `sram_oe_n` is low.
- R3: `sram_dq_oe` is high only while `sram_we_n` is low and the chip is selected (`sram_ce_n`=0, `sram_ce`=1). Address and `sram_dq_out` stay constant for the whole write pulse.
- R4: A read holds the chip selected, `sram_oe_n` low and the address constant for RD cycles, where RD is the ceiling of the larger of read cycle time and access time (55/70 ns) over the clock period. `sram_dq_in` is sampled at the clock edge that ends the last of those cycles and is returned on `rdata`. The default setting (20 ns, grade 0) gives RD=3.
- R5: A write holds `sram_we_n` low for WP cycles, where WP is the ceiling of the largest of write pulse width (40/50 ns), data setup (25/30 ns) and address-to-end-of-write (45/60 ns) over the clock period. The word stored at `sram_addr` is the `req_wdata` of the request. The default setting gives WP=3.
- R6: A write keeps the chip selected for at least the ceiling of the write cycle time (55/70 ns) in cycles, adding cycles with `sram_we_n` high when WP is shorter. The default setting gives 3 cycles.
- R7: After a read, the RAM is deselected for TA cycles, the ceiling of the bus release time (20/25 ns) with a floor of one. `sram_dq_oe` does not rise earlier than TA+1 cycles after `sram_oe_n` rises.
- R8: `ready` drops in the cycle after a request is accepted and stays low until the access ends. A request presented while `ready` is low is ignored and never reaches the RAM.
- R9: `done` is a single-cycle pulse. It comes RD+1 cycles after the accepting edge for a read, and WP+REC+1 cycles for a write, where REC is the number of recovery cycles added under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `ready` is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data of the request |
| ready | output | 1 | Controller idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data captured by the last read |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output strobe |
| sram_dq_out | output | DATA_W | Data toward the RAM |
| sram_dq_in | input | DATA_W | Data from the RAM |
| sram_dq_oe | output | 1 | Output enable of the data pad driver |

## Verification
The assertions check on every cycle the properties that hold at any instant: the idle strobe levels, the exclusion between the write and output strobes, the bus-drive window, address and data stability inside a strobe, the first cycle of the post-read gap, and the single-cycle completion pulse. Phase lengths, the instant at which read data is sampled, the minimum turnaround gap, and whether requests made while busy are dropped can only be seen through the bench's scenarios. There, a cycle-counting RAM model returns a poison value until the access time has passed and measures each write pulse and each select window.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WP   = 3'd2,
      ST_WREC = 3'd3,
      ST_TA   = 3'd4
   } sram_st_e;

   function automatic int ns_to_cyc(input int ns, input int period_ns);
      int c;
      c = (ns + period_ns - 1) / period_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int by_grade(input int grade, input int fast_ns, input int slow_ns);
      return (grade == 0) ? fast_ns : slow_ns;
   endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int DATA_W  = 8,
   parameter int RD_CYC  = 3,
   parameter int WP_CYC  = 3,
   parameter int REC_CYC = 0,
   parameter int TA_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output sram_st_e          st,
   output sram_st_e          nxt,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              done_q
);
   localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, TA_CYC));
   localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
   localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);

   logic             cnt_load;
   logic [CNT_W-1:0] cnt_val;
   logic             cnt_zero;
   sram_st_e         wp_exit;
   logic             wp_finishes;

   sram_phase_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .zero     (cnt_zero)
   );

   // The recovery phase exists only when the pulse alone is shorter than the write cycle.
   generate
      if (REC_CYC > 0) begin : g_rec
         assign wp_exit     = ST_WREC;
         assign wp_finishes = 1'b0;
      end else begin : g_norec
         assign wp_exit     = ST_IDLE;
         assign wp_finishes = 1'b1;
      end
   endgenerate

   always_comb begin
      nxt      = st;
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (st)
         ST_IDLE: if (req) begin
            cnt_load = 1'b1;
            if (req_wr) begin
               nxt     = ST_WP;
               cnt_val = WP_LD;
            end else begin
               nxt     = ST_RD;
               cnt_val = RD_LD;
            end
         end
         ST_RD: if (cnt_zero) begin
            nxt      = ST_TA;
            cnt_load = 1'b1;
            cnt_val  = TA_LD;
         end
         ST_WP: if (cnt_zero) begin
            nxt      = wp_exit;
            cnt_load = !wp_finishes;
            cnt_val  = REC_LD;
         end
         ST_WREC: if (cnt_zero) nxt = ST_IDLE;
         ST_TA:   if (cnt_zero) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         st     <= nxt;
         done_q <= (st == ST_RD   && cnt_zero) ||
                   (st == ST_WP   && cnt_zero && wp_finishes) ||
                   (st == ST_WREC && cnt_zero);
         if (st == ST_IDLE && req) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (st == ST_RD && cnt_zero)
            rdata_q <= dq_in;
      end
   end

   p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && req) |=> (st != ST_IDLE));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
   import sram_ctrl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  sram_st_e nxt,
   output logic     ce_n,
   output logic     ce,
   output logic     we_n,
   output logic     oe_n,
   output logic     dq_oe
);
   logic sel_d;
   assign sel_d = (nxt == ST_RD) || (nxt == ST_WP) || (nxt == ST_WREC);

   // Strobes are registered from the next state so that no decode glitch reaches the RAM.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n  <= 1'b1;
         ce    <= 1'b0;
         we_n  <= 1'b1;
         oe_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         ce_n  <= !sel_d;
         ce    <= sel_d;
         we_n  <= (nxt != ST_WP);
         oe_n  <= (nxt != ST_RD);
         dq_oe <= (nxt == ST_WP);
      end
   end

   p_no_fight_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n) && !(dq_oe && !oe_n));
   p_drive_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!we_n && !ce_n && ce));
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 18,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 20,
   parameter int SPEED_GRADE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_ce,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [DATA_W-1:0] sram_dq_out,
   input  logic [DATA_W-1:0] sram_dq_in,
   output logic              sram_dq_oe
);
   localparam int T_RC_NS  = by_grade(SPEED_GRADE, 55, 70);
   localparam int T_AA_NS  = by_grade(SPEED_GRADE, 55, 70);
   localparam int T_OE_NS  = by_grade(SPEED_GRADE, 25, 35);
   localparam int T_WP_NS  = by_grade(SPEED_GRADE, 40, 50);
   localparam int T_DW_NS  = by_grade(SPEED_GRADE, 25, 30);
   localparam int T_AW_NS  = by_grade(SPEED_GRADE, 45, 60);
   localparam int T_WC_NS  = by_grade(SPEED_GRADE, 55, 70);
   localparam int T_HZ_NS  = by_grade(SPEED_GRADE, 20, 25);

   localparam int RD_CYC  = ns_to_cyc(imax(imax(T_RC_NS, T_AA_NS), T_OE_NS), CLK_PERIOD_NS);
   localparam int WP_CYC  = ns_to_cyc(imax(imax(T_WP_NS, T_DW_NS), T_AW_NS), CLK_PERIOD_NS);
   localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
   localparam int REC_CYC = (WC_CYC > WP_CYC) ? WC_CYC - WP_CYC : 0;
   localparam int TA_CYC  = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: ADDR_W and DATA_W must be positive");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("sram_async_ctrl: CLK_PERIOD_NS must be at least 1");
      end
      if (SPEED_GRADE != 0 && SPEED_GRADE != 1) begin : g_bad_grade
         $error("sram_async_ctrl: SPEED_GRADE must be 0 or 1");
      end
   endgenerate

   sram_st_e st;
   sram_st_e nxt;

   sram_seq #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .RD_CYC  (RD_CYC),
      .WP_CYC  (WP_CYC),
      .REC_CYC (REC_CYC),
      .TA_CYC  (TA_CYC)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_wr    (req_wr),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_in     (sram_dq_in),
      .st        (st),
      .nxt       (nxt),
      .addr_q    (sram_addr),
      .wdata_q   (sram_dq_out),
      .rdata_q   (rdata),
      .done_q    (done)
   );

   sram_pin_reg i_pins (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt   (nxt),
      .ce_n  (sram_ce_n),
      .ce    (sram_ce),
      .we_n  (sram_we_n),
      .oe_n  (sram_oe_n),
      .dq_oe (sram_dq_oe)
   );

   assign ready = (st == ST_IDLE);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe));
   p_wr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));
   p_rd_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_oe_n && !$past(sram_oe_n)) |-> $stable(sram_addr));
   p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |=> !sram_dq_oe);
endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
   localparam int AW = 18;
   localparam int DW = 8;
   localparam int PER = 20;

   function automatic int cyc(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction

   // Expected phase lengths for grade 0 at 20 ns, worked out from the requirements.
   localparam int E_RD  = 3;
   localparam int E_WP  = 3;
   localparam int E_WC  = 3;
   localparam int E_REC = 0;
   localparam int E_TA  = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic ready, done;
   logic [DW-1:0] rdata;
   logic [AW-1:0] sram_addr;
   logic sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [DW-1:0] sram_dq_out;
   logic [DW-1:0] sram_dq_in = 8'hEE;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [DW-1:0] ram [int];
   logic [DW-1:0] expv [int];

   always #(PER/2) clk = ~clk;

   sram_async_ctrl i_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
      .req_wdata(req_wdata), .ready(ready), .done(done), .rdata(rdata),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
      .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] ram_rd(input int a);
      return ram.exists(a) ? ram[a] : 8'h00;
   endfunction

   function automatic logic [DW-1:0] exp_of(input int a);
      return expv.exists(a) ? expv[a] : 8'h00;
   endfunction

   // RAM model: poison data until the access time has passed, pulse and select measurement.
   int rd_cnt = 0;
   int rd_a = -1;
   int wr_cnt = 0;
   int wr_a = 0;
   logic [DW-1:0] wr_d = '0;
   int sel_len = 0;
   int last_sel = 0;
   int gap = 100;
   logic oe_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!sram_ce_n && sram_ce) sel_len++;
         else begin
            if (sel_len > 0) last_sel = sel_len;
            sel_len = 0;
         end
         if (!sram_ce_n && sram_ce && !sram_oe_n && sram_we_n) begin
            if (int'(sram_addr) == rd_a && rd_cnt > 0) rd_cnt++;
            else rd_cnt = 1;
            rd_a = int'(sram_addr);
            sram_dq_in <= (rd_cnt >= E_RD) ? ram_rd(rd_a) : 8'hEE;
         end else begin
            rd_cnt = 0;
            sram_dq_in <= 8'hEE;
         end
         if (!sram_ce_n && sram_ce && !sram_we_n) begin
            wr_cnt++;
            if (!sram_dq_oe) chk(1'b0, "R3 bus not driven in pulse", 0, 1);
            wr_a = int'(sram_addr);
            wr_d = sram_dq_out;
         end else if (wr_cnt > 0) begin
            chk(wr_cnt == E_WP, "R5 write pulse cycles", wr_cnt, E_WP);
            ram[wr_a] = wr_d;
            wr_cnt = 0;
         end
         if (!sram_we_n && !sram_oe_n) chk(1'b0, "R2 strobes both low", 0, 1);
         if (!sram_oe_n) gap = 0;
         else begin
            if (sram_dq_oe && !oe_prev) chk(gap >= E_TA + 1, "R7 turnaround gap", gap, E_TA + 1);
            gap++;
         end
         oe_prev = sram_dq_oe;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic chk_idle(input string rq);
      chk(sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe, rq,
          {sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d, input bit stray);
      int lat;
      while (!ready) step();
      req = 1'b1; req_wr = 1'b1; req_addr = AW'(a); req_wdata = d;
      step();
      lat = 1;
      req = 1'b0;
      chk(!ready, "R8 ready low while busy", ready, 0);
      if (stray) begin
         req = 1'b1; req_wr = 1'b1; req_addr = AW'(a) ^ 18'h155; req_wdata = ~d;
      end
      while (!done && lat < 50) begin
         step();
         lat++;
         if (lat == 2) req = 1'b0;
      end
      chk(lat == E_WP + E_REC + 1, "R9 write latency", lat, E_WP + E_REC + 1);
      expv[a] = d;
      step();
      chk(!done, "R9 done single pulse", done, 0);
      chk(ram_rd(a) == d, "R5 stored word", ram_rd(a), d);
      chk(last_sel >= E_WC, "R6 write select cycles", last_sel, E_WC);
      if (ready) chk_idle("R1 idle after write");
   endtask

   task automatic do_read(input int a);
      int lat;
      while (!ready) step();
      req = 1'b1; req_wr = 1'b0; req_addr = AW'(a);
      step();
      lat = 1;
      req = 1'b0;
      while (!done && lat < 50) begin
         step();
         lat++;
      end
      chk(lat == E_RD + 1, "R9 read latency", lat, E_RD + 1);
      chk(rdata == exp_of(a), "R4 read data", rdata, exp_of(a));
      step();
      chk(!done, "R9 done single pulse", done, 0);
      chk(ready, "R7 idle after turnaround", ready, 1);
      if (ready) chk_idle("R1 idle after read");
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic t_reset();
      step(); step();
      chk(ready, "R1 ready in reset", ready, 1);
      chk_idle("R1 pins in reset");
      chk(!done, "R1 done in reset", done, 0);
      rst_n = 1'b1;
      step();
      chk_idle("R1 pins after reset");
   endtask

   task automatic t_edges();
      do_write(0, 8'h5A, 1'b0);
      do_read(0);
      do_write(18'h3FFFF, 8'hA5, 1'b0);
      do_read(18'h3FFFF);
   endtask

   task automatic t_turnaround();
      do_read(18'h3FFFF);
      do_write(18'h12345, 8'h3C, 1'b0);
      do_read(18'h12345);
   endtask

   task automatic t_stray();
      do_write(18'h00100, 8'h11, 1'b1);
      chk(ram_rd(18'h00055) == 8'h00, "R8 stray request ignored", ram_rd(18'h00055), 0);
      do_read(18'h00055);
      do_read(18'h00100);
   endtask

   task automatic t_patterns();
      for (int i = 0; i < 6; i++) do_write(18'h20000 + i * 18'h0111, 8'(8'h01 << i) | 8'h80, 1'b0);
      for (int i = 5; i >= 0; i--) do_read(18'h20000 + i * 18'h0111);
      do_write(0, 8'hC3, 1'b0);
      do_read(0);
   endtask

   initial begin
      if (cyc(55) != E_RD || cyc(45) != E_WP || cyc(20) != E_TA)
         chk(1'b0, "R4 bench timing table", cyc(55), E_RD);
      t_reset();
      t_edges();
      t_turnaround();
      t_stray();
      t_patterns();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 0, 1);
         summary();
         $finish;
      end
   end
endmodule